// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block sits on the host side of a configuration fabric and turns two software-visible ports into configuration transactions. The first is the address port. It holds a 32-bit selector word: an enable flag in bit 31, a bus number, a device/function number and a register offset. The second is the data port. Each access to it is forwarded to the downstream configuration fabric as a read or a write, and the downstream side answers whether the addressed function exists.

The bridge applies every rule that decides whether an access reaches a device. Data-port accesses need the enable flag. The low two bits of the data-port access offset are ORed into the register offset, so narrow accesses reach the correct byte lane. Offsets at or past the configuration space size are refused, and the length is clipped so that an access never runs past the end of the space. A device that is missing, that is disabled, or that is a non-zero function with no function 0 is treated as absent. Every refused read returns all ones.

The host interface takes one access at a time with a valid/ready handshake and answers with a one-cycle response strobe. Writes are resolved in two phases. A probe first returns the device flags, and a separate commit strobe is raised only if the device is present. Because of this, a refused write never changes any device.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the selector word is zero, `hostReady` is 1, and `rspValid`, `dnValid` and `dnCommit` are 0. A read of the address port then returns 0.
- R2: An address-port write (`hostSel`=0, `hostWrite`=1) stores `hostWdata` only when `hostOffset`=0 and `hostLen`=4. Every other address-port write leaves the selector unchanged. Every address-port write completes with `rspData` all ones.
- R3: An address-port read returns the whole 32-bit selector word, whatever the `hostOffset` and `hostLen`.
- R4: When selector bit 31 is 0, a data-port access (`hostSel`=1) issues no downstream request. A read returns 0xFFFFFFFF, and a write changes nothing.
- R5: A forwarded request carries `dnBus` = selector[23:16], `dnDevFn` = selector[15:8] and `dnOffset` = selector[7:0] OR `hostOffset`.
- R6: A data-port access whose merged offset is at or above `SPACE_BYTES` issues no downstream request. It reads as all ones, and a write is ignored.
- R7: `dnLen` equals the smaller of min(`hostLen`, 4) and `SPACE_BYTES` minus the merged offset.
- R8: When the downstream response has `dnPresent`=0, a read returns all ones and a write raises no `dnCommit`.
- R9: A function with `dnEnabled`=0 is treated as absent, and so is a function with a non-zero function number (`dnDevFn`[2:0]) and `dnFunc0Present`=0.
- R10: For a present function, a read returns `dnRdata` with `rspValid` high in the cycle after the `dnDone` cycle.
- R11: For a present function, a write raises `dnCommit` for exactly one cycle, in the cycle after `dnDone`, with unchanged request fields. `rspValid` follows in the next cycle with `rspData` all ones.
- R12: Only one access is outstanding at a time. `hostReady` is high only while idle, and `rspValid` is a one-cycle pulse. Address-port accesses and refused data-port accesses respond in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Bridge idle, access accepted when both high |
| hostSel | input | 1 | 0 = address port, 1 = data port |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 2 | Byte offset of the access within the port |
| hostLen | input | 3 | Access length in bytes (1 to 4, larger values act as 4) |
| hostWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle completion strobe |
| rspData | output | 32 | Read result, all ones on writes and refusals |
| dnValid | output | 1 | Downstream probe/read request, held until dnDone |
| dnCommit | output | 1 | One-cycle write commit strobe |
| dnWrite | output | 1 | Request is a write |
| dnBus | output | 8 | Bus number |
| dnDevFn | output | 8 | Device/function number |
| dnOffset | output | 8 | Register byte offset |
| dnLen | output | 3 | Clipped byte length |
| dnWdata | output | 32 | Write data, lowest byte at dnOffset |
| dnDone | input | 1 | Downstream response strobe |
| dnRdata | input | 32 | Read data, lowest byte from dnOffset |
| dnPresent | input | 1 | Addressed function exists |
| dnEnabled | input | 1 | Addressed function is enabled |
| dnFunc0Present | input | 1 | Function 0 of the addressed device exists |

## Verification
An access is accepted at the rising edge where `hostValid` and `hostReady` are both high. Address-port accesses and refused data-port accesses must raise `rspValid` one cycle after that edge. A forwarded read must respond one cycle after the `dnDone` cycle. A forwarded write must commit in the cycle after `dnDone` and respond one cycle later. The bench drives and samples on falling edges and counts cycles from acceptance to the response. It records what it saw in the sample just before `rspValid`: a `dnDone` or a `dnCommit`. It also captures the request fields while `dnValid` is high, and compares every read against a shadow copy of the configuration bytes.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int OFF_W    = 8;   // register offset field width
  localparam int BUS_W    = 8;
  localparam int DEVFN_W  = 8;
  localparam int FUNC_W   = 3;   // low bits of device/function hold the function
  localparam int BUS_LSB  = 16;
  localparam int DEVFN_LSB = 8;
  localparam int EN_BIT   = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_COMMIT, ST_RESP} ctrlState_t;
  typedef enum logic [1:0] {RSP_KEEP, RSP_ONES, RSP_ADDR, RSP_DOWN} rspSrc_t;

  typedef struct packed {
    logic    loadAddr;
    logic    loadReq;
    rspSrc_t rspSrc;
  } dpStrobe_t;
endpackage

// File: rtl/cfg_bridge_dp.sv
module cfg_bridge_dp
  import cfg_bridge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SPACE_BYTES = 256,
  parameter int MAX_LEN     = 4,
  parameter int LEN_W       = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                hostWrite,
  input  logic [1:0]          hostOffset,
  input  logic [LEN_W-1:0]    hostLen,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   dnRdata,
  input  logic                dnPresent,
  input  logic                dnEnabled,
  input  logic                dnFunc0Present,
  output logic [DATA_W-1:0]   addrWord,
  output logic                gateOk,
  output logic                reqWrite,
  output logic                devAbsent,
  output logic [BUS_W-1:0]    dnBus,
  output logic [DEVFN_W-1:0]  dnDevFn,
  output logic [OFF_W-1:0]    dnOffset,
  output logic [LEN_W-1:0]    dnLen,
  output logic [DATA_W-1:0]   dnWdata,
  output logic [DATA_W-1:0]   rspData
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic [DATA_W-1:0]  addrQ;
  logic [OFF_W-1:0]   mergedOff;
  logic [LEN_W-1:0]   capLen;
  logic [LEN_W-1:0]   clipLen;
  logic               inRange;
  int                 roomBytes;

  logic [BUS_W-1:0]   reqBus;
  logic [DEVFN_W-1:0] reqDevFn;
  logic [OFF_W-1:0]   reqOff;
  logic [LEN_W-1:0]   reqLen;
  logic [DATA_W-1:0]  reqData;
  logic               reqWriteQ;
  logic [DATA_W-1:0]  rspQ;

  // offset merge, range test and length clipping
  always_comb begin
    mergedOff = addrQ[OFF_W-1:0] | OFF_W'(hostOffset);
    roomBytes = SPACE_BYTES - int'(mergedOff);
    inRange   = int'(mergedOff) < SPACE_BYTES;
    capLen    = (hostLen > LEN_CAP) ? LEN_CAP : hostLen;
    if (int'(capLen) > roomBytes)
      clipLen = LEN_W'(roomBytes);
    else
      clipLen = capLen;
    gateOk = addrQ[EN_BIT] && inRange;
  end

  // presence decision from the downstream flags
  always_comb begin
    devAbsent = !dnPresent || !dnEnabled ||
                ((reqDevFn[FUNC_W-1:0] != '0) && !dnFunc0Present);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.loadAddr) begin
      addrQ <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBus    <= '0;
      reqDevFn  <= '0;
      reqOff    <= '0;
      reqLen    <= '0;
      reqData   <= '0;
      reqWriteQ <= 1'b0;
    end else if (strobe.loadReq) begin
      reqBus    <= addrQ[BUS_LSB +: BUS_W];
      reqDevFn  <= addrQ[DEVFN_LSB +: DEVFN_W];
      reqOff    <= mergedOff;
      reqLen    <= clipLen;
      reqData   <= hostWdata;
      reqWriteQ <= hostWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspQ <= '1;
    end else begin
      case (strobe.rspSrc)
        RSP_ONES: rspQ <= '1;
        RSP_ADDR: rspQ <= addrQ;
        RSP_DOWN: rspQ <= dnRdata;
        default:  rspQ <= rspQ;
      endcase
    end
  end

  assign addrWord = addrQ;
  assign reqWrite = reqWriteQ;
  assign dnBus    = reqBus;
  assign dnDevFn  = reqDevFn;
  assign dnOffset = reqOff;
  assign dnLen    = reqLen;
  assign dnWdata  = reqData;
  assign rspData  = rspQ;
endmodule

// File: rtl/cfg_bridge_ctrl.sv
module cfg_bridge_ctrl
  import cfg_bridge_pkg::*;
#(
  parameter int MAX_LEN = 4,
  parameter int LEN_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  input  logic             hostSel,
  input  logic             hostWrite,
  input  logic [1:0]       hostOffset,
  input  logic [LEN_W-1:0] hostLen,
  input  logic             gateOk,
  input  logic             reqWrite,
  input  logic             devAbsent,
  input  logic             dnDone,
  output dpStrobe_t        strobe,
  output logic             hostReady,
  output logic             dnValid,
  output logic             dnCommit,
  output logic             rspValid
);
  localparam logic [LEN_W-1:0] FULL_WORD = LEN_W'(MAX_LEN);

  ctrlState_t state;
  ctrlState_t nextState;

  always_comb begin
    nextState       = state;
    strobe.loadAddr = 1'b0;
    strobe.loadReq  = 1'b0;
    strobe.rspSrc   = RSP_KEEP;
    case (state)
      ST_IDLE: begin
        if (hostValid) begin
          if (!hostSel) begin
            if (hostWrite) begin
              strobe.loadAddr = (hostOffset == 2'd0) && (hostLen == FULL_WORD);
              strobe.rspSrc   = RSP_ONES;
            end else begin
              strobe.rspSrc = RSP_ADDR;
            end
            nextState = ST_RESP;
          end else if (gateOk) begin
            strobe.loadReq = 1'b1;
            nextState      = ST_PROBE;
          end else begin
            strobe.rspSrc = RSP_ONES;
            nextState     = ST_RESP;
          end
        end
      end
      ST_PROBE: begin
        if (dnDone) begin
          if (devAbsent || reqWrite)
            strobe.rspSrc = RSP_ONES;
          else
            strobe.rspSrc = RSP_DOWN;
          nextState = (!devAbsent && reqWrite) ? ST_COMMIT : ST_RESP;
        end
      end
      ST_COMMIT: nextState = ST_RESP;
      ST_RESP:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign hostReady = (state == ST_IDLE);
  assign dnValid   = (state == ST_PROBE);
  assign dnCommit  = (state == ST_COMMIT);
  assign rspValid  = (state == ST_RESP);
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int SPACE_BYTES = 256,
  parameter int DATA_W      = 32,
  parameter int MAX_LEN     = 4,
  parameter int LEN_W       = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  output logic               hostReady,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [1:0]         hostOffset,
  input  logic [LEN_W-1:0]   hostLen,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               dnValid,
  output logic               dnCommit,
  output logic               dnWrite,
  output logic [BUS_W-1:0]   dnBus,
  output logic [DEVFN_W-1:0] dnDevFn,
  output logic [OFF_W-1:0]   dnOffset,
  output logic [LEN_W-1:0]   dnLen,
  output logic [DATA_W-1:0]  dnWdata,
  input  logic               dnDone,
  input  logic [DATA_W-1:0]  dnRdata,
  input  logic               dnPresent,
  input  logic               dnEnabled,
  input  logic               dnFunc0Present
);
  dpStrobe_t         strobe;
  logic              gateOk;
  logic              reqWrite;
  logic              devAbsent;
  logic [DATA_W-1:0] addrWord;

  cfg_bridge_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .hostLen(hostLen),
    .gateOk(gateOk), .reqWrite(reqWrite), .devAbsent(devAbsent), .dnDone(dnDone),
    .strobe(strobe), .hostReady(hostReady), .dnValid(dnValid),
    .dnCommit(dnCommit), .rspValid(rspValid)
  );

  cfg_bridge_dp #(
    .DATA_W(DATA_W), .SPACE_BYTES(SPACE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWrite(hostWrite), .hostOffset(hostOffset), .hostLen(hostLen), .hostWdata(hostWdata),
    .dnRdata(dnRdata), .dnPresent(dnPresent), .dnEnabled(dnEnabled),
    .dnFunc0Present(dnFunc0Present),
    .addrWord(addrWord), .gateOk(gateOk), .reqWrite(reqWrite), .devAbsent(devAbsent),
    .dnBus(dnBus), .dnDevFn(dnDevFn), .dnOffset(dnOffset), .dnLen(dnLen),
    .dnWdata(dnWdata), .rspData(rspData)
  );

  assign dnWrite = reqWrite;
endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk #(
  parameter int SPACE_BYTES = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostValid,
  input logic        hostReady,
  input logic        hostSel,
  input logic        hostWrite,
  input logic [1:0]  hostOffset,
  input logic [2:0]  hostLen,
  input logic        rspValid,
  input logic        dnValid,
  input logic        dnDone,
  input logic        dnCommit,
  input logic [7:0]  dnOffset,
  input logic [2:0]  dnLen,
  input logic [31:0] addrWord
);
  // R2: selector changes only after an accepted full-word write at offset 0
  assert_addr_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrWord) |-> $past(hostValid && hostReady && !hostSel && hostWrite &&
                                 hostOffset == 2'd0 && hostLen == 3'd4));

  // R4: no downstream request while the enable bit is clear
  assert_probe_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> addrWord[31]);

  // R6 / R7: request stays inside the configuration space
  assert_inside_space_R6: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> (int'(dnOffset) + int'(dnLen) <= SPACE_BYTES) && dnLen != 3'd0);

  // R11: commit only right after a response, never overlapping a probe
  assert_commit_after_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    dnCommit |-> $past(dnDone) && !dnValid);

  // R11: request fields hold from probe to commit
  assert_commit_fields_R11: assert property (@(posedge clk) disable iff (!rstN)
    dnCommit |-> $stable(dnOffset) && $stable(dnLen));

  // R12: response is a single-cycle pulse and no new access is taken meanwhile
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid || dnCommit || rspValid) |-> !hostReady);

  // R12: a held probe keeps its offset until answered
  assert_probe_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnDone |=> dnValid && $stable(dnOffset));
endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(.SPACE_BYTES(SPACE_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .hostSel(hostSel), .hostWrite(hostWrite), .hostOffset(hostOffset), .hostLen(hostLen),
  .rspValid(rspValid), .dnValid(dnValid), .dnDone(dnDone), .dnCommit(dnCommit),
  .dnOffset(dnOffset), .dnLen(dnLen), .addrWord(addrWord)
);

// File: tb/test_cfg_access_bridge.sv
module test_cfg_access_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 192;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk, rstN;
  logic        hostValid, hostReady, hostSel, hostWrite;
  logic [1:0]  hostOffset;
  logic [2:0]  hostLen;
  logic [31:0] hostWdata;
  logic        rspValid;
  logic [31:0] rspData;
  logic        dnValid, dnCommit, dnWrite;
  logic [7:0]  dnBus, dnDevFn, dnOffset;
  logic [2:0]  dnLen;
  logic [31:0] dnWdata;
  logic        dnDone, dnPresent, dnEnabled, dnFunc0Present;
  logic [31:0] dnRdata;

  cfg_access_bridge #(.SPACE_BYTES(LIMIT)) i_cfg_access_bridge (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostSel(hostSel), .hostWrite(hostWrite), .hostOffset(hostOffset), .hostLen(hostLen),
    .hostWdata(hostWdata), .rspValid(rspValid), .rspData(rspData),
    .dnValid(dnValid), .dnCommit(dnCommit), .dnWrite(dnWrite), .dnBus(dnBus),
    .dnDevFn(dnDevFn), .dnOffset(dnOffset), .dnLen(dnLen), .dnWdata(dnWdata),
    .dnDone(dnDone), .dnRdata(dnRdata), .dnPresent(dnPresent), .dnEnabled(dnEnabled),
    .dnFunc0Present(dnFunc0Present)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int checks = 0, fails = 0;
  int commitCount = 0, probeCount = 0;
  int waitLeft = 0;
  bit finished = 0;
  logic [7:0]  devMem [0:4095];
  logic [7:0]  refMem [0:4095];
  logic [31:0] refAddr;

  function automatic int memIndex(logic [7:0] bus, logic [7:0] devfn, logic [7:0] off);
    return int'({bus[0], devfn[4:3], devfn[0], off});
  endfunction

  // downstream fabric population
  function automatic bit slotFilled(logic [7:0] bus, logic [7:0] devfn);
    return (bus < 8'd2) && (devfn[7:3] < 5'd4) &&
           !(bus == 8'd0 && devfn[7:3] == 5'd2 && devfn[2:0] == 3'd0);
  endfunction
  function automatic bit slotEnabled(logic [7:0] bus, logic [7:0] devfn);
    return !(bus == 8'd1 && devfn[7:3] == 5'd3);
  endfunction
  // host-visible view, written from the rules
  function automatic bit expVisible(logic [7:0] bus, logic [7:0] devfn);
    if (bus >= 8'd2 || devfn[7:3] >= 5'd4) return 0;
    if (bus == 8'd1 && devfn[7:3] == 5'd3) return 0;   // disabled
    if (bus == 8'd0 && devfn[7:3] == 5'd2) return 0;   // function 0 missing
    return 1;
  endfunction

  function automatic int clipN(logic [7:0] o, int len);
    int n;
    n = (len > 4) ? 4 : len;
    if (n > LIMIT - int'(o)) n = LIMIT - int'(o);
    return n;
  endfunction

  function automatic logic [31:0] expRead(logic [31:0] a, logic [1:0] off, int len);
    logic [7:0]  o;
    logic [31:0] r;
    int n, base;
    o = a[7:0] | {6'b0, off};
    if (!a[31] || int'(o) >= LIMIT || !expVisible(a[23:16], a[15:8])) return ONES;
    n = clipN(o, len);
    base = memIndex(a[23:16], a[15:8], o);
    r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = refMem[base + i];
    return r;
  endfunction

  // downstream model
  always @(posedge clk) begin
    dnDone <= 1'b0;
    if (!rstN) begin
      waitLeft <= 0;
    end else begin
      if (dnValid && !dnDone) begin
        if (waitLeft == 0) begin
          logic [31:0] rd;
          int base;
          base = memIndex(dnBus, dnDevFn, dnOffset);
          rd = '0;
          for (int i = 0; i < int'(dnLen) && i < 4; i++)
            if (base + i < 4096) rd[8*i +: 8] = devMem[base + i];
          dnDone         <= 1'b1;
          dnRdata        <= rd;
          dnPresent      <= slotFilled(dnBus, dnDevFn);
          dnEnabled      <= slotEnabled(dnBus, dnDevFn);
          dnFunc0Present <= slotFilled(dnBus, {dnDevFn[7:3], 3'b000});
          probeCount     <= probeCount + 1;
          waitLeft       <= int'($urandom_range(0, 2));
        end else begin
          waitLeft <= waitLeft - 1;
        end
      end
      if (dnCommit) begin
        for (int i = 0; i < int'(dnLen) && i < 4; i++)
          if (memIndex(dnBus, dnDevFn, dnOffset) + i < 4096)
            devMem[memIndex(dnBus, dnDevFn, dnOffset) + i] <= dnWdata[8*i +: 8];
        commitCount <= commitCount + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one host access; returns data, latency and what preceded the response
  logic [31:0] lastRd;
  int          lastLat;
  bit          lastAfterDone, lastAfterCommit, sawProbe;
  logic [7:0]  capOff, capBus, capDevFn;
  logic [2:0]  capLen;

  task automatic access(input bit sel, input bit wr, input logic [1:0] off,
                        input int len, input logic [31:0] wd);
    bit prevDone, prevCommit;
    @(negedge clk);
    hostValid = 1'b1; hostSel = sel; hostWrite = wr;
    hostOffset = off; hostLen = 3'(len); hostWdata = wd;
    @(negedge clk);
    hostValid = 1'b0;
    lastLat = 1; prevDone = 0; prevCommit = 0; sawProbe = 0;
    while (!rspValid && lastLat < 60) begin
      if (dnValid && !sawProbe) begin
        sawProbe = 1; capOff = dnOffset; capLen = dnLen; capBus = dnBus; capDevFn = dnDevFn;
      end
      prevDone = dnDone; prevCommit = dnCommit;
      @(negedge clk);
      lastLat++;
    end
    lastAfterDone = prevDone;
    lastAfterCommit = prevCommit;
    lastRd = rspData;
    check(rspValid === 1'b1, "R12", "response seen", {31'b0, rspValid}, 32'd1);
  endtask

  task automatic doAccess(input bit sel, input bit wr, input logic [1:0] off,
                          input int len, input logic [31:0] wd);
    int p0, c0;
    logic [31:0] exp;
    logic [7:0] o;
    bit gated;
    p0 = probeCount; c0 = commitCount;
    exp = expRead(refAddr, off, len);
    access(sel, wr, off, len, wd);
    if (!sel) begin
      check(lastLat == 1, "R12", "address port latency", 32'(lastLat), 32'd1);
      if (wr) begin
        check(lastRd == ONES, "R2", "address write response", lastRd, ONES);
        if (off == 2'd0 && len == 4) refAddr = wd;
      end else begin
        check(lastRd == refAddr, "R3", "address read", lastRd, refAddr);
      end
    end else begin
      o = refAddr[7:0] | {6'b0, off};
      gated = !refAddr[31] || int'(o) >= LIMIT;
      if (gated) begin
        check(probeCount == p0, refAddr[31] ? "R6" : "R4", "no downstream request",
              32'(probeCount - p0), 32'd0);
        check(lastLat == 1, "R12", "refused latency", 32'(lastLat), 32'd1);
        check(lastRd == ONES, refAddr[31] ? "R6" : "R4", "refused data", lastRd, ONES);
      end else begin
        check(probeCount == p0 + 1, "R5", "one probe", 32'(probeCount - p0), 32'd1);
        check(capOff == o && capBus == refAddr[23:16] && capDevFn == refAddr[15:8], "R5",
              "forwarded offset", {8'b0, capBus, capDevFn, capOff},
              {8'b0, refAddr[23:16], refAddr[15:8], o});
        check(int'(capLen) == clipN(o, len), "R7", "clipped length",
              32'(capLen), 32'(clipN(o, len)));
        if (!wr) begin
          check(lastRd == exp, expVisible(refAddr[23:16], refAddr[15:8]) ? "R10" : "R8",
                "read data", lastRd, exp);
          check(lastAfterDone, "R10", "response follows done", {31'b0, lastAfterDone}, 32'd1);
        end else if (expVisible(refAddr[23:16], refAddr[15:8])) begin
          check(commitCount == c0 + 1, "R11", "one commit", 32'(commitCount - c0), 32'd1);
          check(lastAfterCommit, "R11", "response follows commit",
                {31'b0, lastAfterCommit}, 32'd1);
          check(lastRd == ONES, "R11", "write response", lastRd, ONES);
          for (int i = 0; i < clipN(o, len); i++)
            refMem[memIndex(refAddr[23:16], refAddr[15:8], o) + i] = wd[8*i +: 8];
        end else begin
          check(commitCount == c0, "R9", "absent write not committed",
                32'(commitCount - c0), 32'd0);
        end
      end
    end
  endtask

  function automatic logic [31:0] sel32(bit en, int bus, int dev, int fn, int off);
    return {en, 7'b0, 8'(bus), 5'(dev), 3'(fn), 8'(off)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin
      devMem[i] = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    refAddr = '0;
    rstN = 1'b0; hostValid = 1'b0; hostSel = 1'b0; hostWrite = 1'b0;
    hostOffset = '0; hostLen = 3'd4; hostWdata = '0;
    dnDone = 1'b0; dnRdata = '0; dnPresent = 1'b0; dnEnabled = 1'b0; dnFunc0Present = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hostReady === 1'b1 && rspValid === 1'b0 && dnValid === 1'b0 && dnCommit === 1'b0,
          "R1", "reset outputs", {28'b0, hostReady, rspValid, dnValid, dnCommit}, 32'h8);
    access(1'b0, 1'b0, 2'd0, 4, '0);
    check(lastRd == 32'h0, "R1", "selector after reset", lastRd, 32'h0);

    // R4 disabled data port
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'h1234_5678);

    // R2 dropped address writes, then accepted one
    doAccess(1'b0, 1'b1, 2'd0, 2, sel32(1, 0, 1, 0, 8'h10));
    doAccess(1'b0, 1'b1, 2'd1, 4, sel32(1, 0, 1, 0, 8'h10));
    doAccess(1'b0, 1'b0, 2'd3, 1, '0);
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 0, 1, 0, 8'h10));
    doAccess(1'b0, 1'b0, 2'd2, 1, '0);   // R3 full word on narrow read

    // R5 byte lane merge, R10 read, R11 write
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd2, 1, 32'h0000_00AB);
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd1, 2, 32'h0000_C0DE);
    doAccess(1'b1, 1'b0, 2'd0, 7, '0);   // R7 length above 4 acts as 4

    // R7 clipping near the space limit
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 1, 0, 1, LIMIT - 2));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b0, 2'd1, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'hA5A5_5A5A);
    doAccess(1'b1, 1'b0, 2'd0, 2, '0);

    // R6 out of range
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 1, 0, 1, LIMIT));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'hDEAD_BEEF);

    // R8 missing device, R9 disabled device and orphan function
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 5, 1, 0, 8'h04));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'h0BAD_F00D);
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 1, 3, 0, 8'h08));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'h1111_2222);
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 0, 2, 3, 8'h0C));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);
    doAccess(1'b1, 1'b1, 2'd0, 4, 32'h3333_4444);
    doAccess(1'b0, 1'b1, 2'd0, 4, sel32(1, 0, 2, 0, 8'h0C));
    doAccess(1'b1, 1'b0, 2'd0, 4, '0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom_range(0, 7));
      case (kind)
        0: doAccess(1'b0, 1'b1, 2'd0, 4,
                    sel32($urandom_range(0, 3) != 0, $urandom_range(0, 2), $urandom_range(0, 4),
                          $urandom_range(0, 7), $urandom_range(0, 255)));
        1: doAccess(1'b0, 1'b1, 2'($urandom_range(0, 3)), $urandom_range(1, 4), $urandom);
        2: doAccess(1'b0, 1'b0, 2'($urandom_range(0, 3)), $urandom_range(1, 4), '0);
        3, 4, 5: doAccess(1'b1, 1'b0, 2'($urandom_range(0, 3)), $urandom_range(1, 4), '0);
        default: doAccess(1'b1, 1'b1, 2'($urandom_range(0, 3)), $urandom_range(1, 4), $urandom);
      endcase
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule